// File: doc/BRIEF.md
# Vector Rotation Transform Coprocessor

This block converts motor-control quantities between a rotating reference frame and the stationary phase frame. The host sees it as a small register file on a 12-bit parallel bus. Chip select and read strobe are active low, and a write takes effect on the rising edge of the write strobe.

There are two independent paths. The forward path takes a direct and a quadrature value and rotates them by an angle to give a two-axis pair. It then expands that pair into three balanced phase values. The reverse path takes three phase samples and reduces them to a two-axis pair. It then rotates that pair backwards by its own angle to give flux and torque components.

Neither path runs on its own. A path starts when the host writes its angle register, and that write also supplies the angle. An angle code is an unsigned fraction of one full turn scaled by 4096, so 45 degrees is 512. Each path runs on its own iterative shift-and-add rotator and reports busy in a status register.

Top module: `vrot_coproc`

## Requirements
- R1: After reset, every result address (0, 1, 3 to 9) and the status address (2) reads zero.
- R2: Write addresses: 0 direct input, 1 quadrature input, 2 forward angle, 3/4/5 phase A/B/C inputs, 6 reverse angle. A write is taken when the write strobe rises while chip select is low. A strobe with chip select high changes nothing.
- R3: Read addresses: 0 forward X, 1 forward Y, 2 status, 3/4/5 phase outputs A/B/C, 6 alpha, 7 beta, 8 flux (d), 9 torque (q). The data bus drives the selected value only while chip select and read strobe are both low, and reads zero otherwise.
- R4: A write to address 2 with code k starts the forward path with angle th = 2*pi*k/4096. It gives X = D*cos(th) - Q*sin(th) and Y = D*sin(th) + Q*cos(th), each within 3 LSB.
- R5: The phase outputs follow the forward results: A = X, B = -X/2 + (sqrt(3)/2)*Y, C = -X/2 - (sqrt(3)/2)*Y, each within 1 LSB of the value computed from the X and Y read back.
- R6: A write to address 6 captures alpha = (2A - B - C)/3 and beta = (B - C)/sqrt(3) from the phase input registers, each within 1 LSB.
- R7: The reverse path then gives d = alpha*cos(th) + beta*sin(th) and q = -alpha*sin(th) + beta*cos(th), with th taken from the reverse angle code, each within 3 LSB.
- R8: Every result saturates to the two's complement range -2048 to 2047 instead of wrapping.
- R9: Status bit 0 is forward busy and bit 1 is reverse busy; the upper bits are zero. A busy bit sets at the clock edge that takes the angle write and stays set for ITER+1 = 15 cycles. The path's results update at the edge where the bit clears.
- R10: An angle write to a busy path restarts it from the current inputs and the new angle. The busy period then counts again from that write, and only the restarted result appears.
- R11: Addresses 10 to 15 read zero and ignore writes. Writes to the read-only addresses 7 to 9 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe; data is taken on its rising edge |
| addr | input | 4 | Register address |
| wdata | input | 12 | Write data, two's complement values or angle code |
| rdata | output | 12 | Read data, zero when not selected for reading |

## Verification
Writes to the input registers take effect at the first clock edge after the strobe rises. Alpha and beta are captured at that same edge when the reverse angle is written. The rotated results, the phase outputs and the clearing of the busy bit all arrive ITER+1 edges after the edge that takes the angle write. The bench polls the status register once per cycle from the cycle after that edge, and it expects exactly ITER busy readings. It reads a path's results only after the busy bit has cleared. All reads are sampled on the falling half of the clock.

// File: rtl/vrot_pkg.sv
package vrot_pkg;
  parameter int DW  = 12;          // bus and value width
  parameter int AW  = 4;           // register address width
  parameter int GW  = 4;           // guard fraction bits in the rotator
  parameter int IW  = DW + GW + 4; // rotator datapath width
  parameter int ZFB = 16;          // angle accumulator units per turn, log2
  parameter int ZW  = ZFB + 2;     // signed angle accumulator width
  parameter int CF  = 15;          // fraction bits of fixed-point constants
  parameter int KW  = 17;          // width of the gain correction constant

  localparam logic signed [KW-1:0] KINV    = 17'sd19899; // 1/1.64676 in Q15
  localparam logic signed [39:0]   C_THIRD = 40'sd10923; // 1/3
  localparam logic signed [39:0]   C_RSQ3  = 40'sd18919; // 1/sqrt(3)
  localparam logic signed [39:0]   C_HSQ3  = 40'sd28378; // sqrt(3)/2
  localparam logic signed [39:0]   C_HALF  = 40'sd16384; // 1/2
  localparam logic signed [39:0]   C_RND   = 40'sd1 <<< (CF - 1);
  localparam logic signed [39:0]   SMAX    = (40'sd1 <<< (DW - 1)) - 40'sd1;
  localparam logic signed [39:0]   SMIN    = -(40'sd1 <<< (DW - 1));

  // write decode
  localparam logic [AW-1:0] WA_VD   = 4'd0;
  localparam logic [AW-1:0] WA_VQ   = 4'd1;
  localparam logic [AW-1:0] WA_FANG = 4'd2;
  localparam logic [AW-1:0] WA_PA   = 4'd3;
  localparam logic [AW-1:0] WA_PB   = 4'd4;
  localparam logic [AW-1:0] WA_PC   = 4'd5;
  localparam logic [AW-1:0] WA_RANG = 4'd6;
  // read decode
  localparam logic [AW-1:0] RA_FX   = 4'd0;
  localparam logic [AW-1:0] RA_FY   = 4'd1;
  localparam logic [AW-1:0] RA_STAT = 4'd2;
  localparam logic [AW-1:0] RA_OA   = 4'd3;
  localparam logic [AW-1:0] RA_OB   = 4'd4;
  localparam logic [AW-1:0] RA_OC   = 4'd5;
  localparam logic [AW-1:0] RA_AL   = 4'd6;
  localparam logic [AW-1:0] RA_BE   = 4'd7;
  localparam logic [AW-1:0] RA_D    = 4'd8;
  localparam logic [AW-1:0] RA_Q    = 4'd9;

  // arctan(2^-i) in units of 1/65536 turn
  function automatic logic signed [ZW-1:0] atan_step(input int i);
    case (i)
      0:  return ZW'(8192);
      1:  return ZW'(4836);
      2:  return ZW'(2555);
      3:  return ZW'(1297);
      4:  return ZW'(651);
      5:  return ZW'(326);
      6:  return ZW'(163);
      7:  return ZW'(81);
      8:  return ZW'(41);
      9:  return ZW'(20);
      10: return ZW'(10);
      11: return ZW'(5);
      12: return ZW'(3);
      13: return ZW'(1);
      default: return '0;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] sat_dw(input logic signed [39:0] v);
    if (v > SMAX)      return SMAX[DW-1:0];
    else if (v < SMIN) return SMIN[DW-1:0];
    else               return v[DW-1:0];
  endfunction
endpackage

// File: rtl/vrot_cordic.sv
module vrot_cordic
  import vrot_pkg::*;
#(
  parameter int ITER = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DW-1:0]        ang,
  input  logic signed [DW-1:0] xin,
  input  logic signed [DW-1:0] yin,
  output logic                 busy,
  output logic signed [DW-1:0] xout,
  output logic signed [DW-1:0] yout
);
  localparam int CW  = $clog2(ITER + 1);
  localparam int ZSH = ZFB - DW;
  localparam int SH  = CF + GW;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SCALE} st_e;

  st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic signed [IW-1:0] x_q, y_q, x_d, y_d;
  logic signed [IW-1:0] xe, ye, xr, yr, xs, ys;
  logic signed [ZW-1:0] z_q, z_d, z0, at;
  logic signed [DW-1:0] xo_q, yo_q, xo_d, yo_d;
  logic signed [IW+KW-1:0] px, py;
  logic signed [39:0] pxr, pyr;
  logic dp_en, out_en;

  // quadrant pre-rotation, residual angle, one micro-rotation, gain fix
  always_comb begin
    xe = IW'(xin) <<< GW;
    ye = IW'(yin) <<< GW;
    unique case (ang[DW-1 -: 2])
      2'd0:    begin xr = xe;  yr = ye;  end
      2'd1:    begin xr = -ye; yr = xe;  end
      2'd2:    begin xr = -xe; yr = -ye; end
      default: begin xr = ye;  yr = -xe; end
    endcase
    z0  = signed'(ZW'({ang[DW-3:0], {ZSH{1'b0}}}));
    at  = atan_step(int'(cnt_q));
    xs  = x_q >>> cnt_q;
    ys  = y_q >>> cnt_q;
    px  = x_q * KINV;
    py  = y_q * KINV;
    pxr = (40'(px) + (40'sd1 <<< (SH - 1))) >>> SH;
    pyr = (40'(py) + (40'sd1 <<< (SH - 1))) >>> SH;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    x_d    = x_q;
    y_d    = y_q;
    z_d    = z_q;
    xo_d   = sat_dw(pxr);
    yo_d   = sat_dw(pyr);
    dp_en  = 1'b0;
    out_en = 1'b0;
    if (start) begin
      dp_en = 1'b1;
      st_d  = ST_RUN;
      cnt_d = '0;
      x_d   = xr;
      y_d   = yr;
      z_d   = z0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          dp_en = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (z_q[ZW-1]) begin
            x_d = x_q + ys;
            y_d = y_q - xs;
            z_d = z_q + at;
          end else begin
            x_d = x_q - ys;
            y_d = y_q + xs;
            z_d = z_q - at;
          end
          if (cnt_q == CW'(ITER - 1)) st_d = ST_SCALE;
        end
        ST_SCALE: begin
          out_en = 1'b1;
          st_d   = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      xo_q  <= '0;
      yo_q  <= '0;
    end else begin
      st_q <= st_d;
      if (dp_en) begin
        cnt_q <= cnt_d;
        x_q   <= x_d;
        y_q   <= y_d;
        z_q   <= z_d;
      end
      if (out_en) begin
        xo_q <= xo_d;
        yo_q <= yo_d;
      end
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign xout = xo_q;
  assign yout = yo_q;
endmodule

// File: rtl/vrot_clarke.sv
module vrot_clarke
  import vrot_pkg::*;
(
  input  logic signed [DW-1:0] pa,
  input  logic signed [DW-1:0] pb,
  input  logic signed [DW-1:0] pc,
  output logic signed [DW-1:0] alpha,
  output logic signed [DW-1:0] beta
);
  logic signed [39:0] sa, sb, ta, tb;

  always_comb begin
    sa    = 40'(pa) * 40'sd2 - 40'(pb) - 40'(pc);
    sb    = 40'(pb) - 40'(pc);
    ta    = (sa * C_THIRD + C_RND) >>> CF;
    tb    = (sb * C_RSQ3 + C_RND) >>> CF;
    alpha = sat_dw(ta);
    beta  = sat_dw(tb);
  end
endmodule

// File: rtl/vrot_iclarke.sv
module vrot_iclarke
  import vrot_pkg::*;
(
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] y,
  output logic signed [DW-1:0] pa,
  output logic signed [DW-1:0] pb,
  output logic signed [DW-1:0] pc
);
  logic signed [39:0] hx, sy;
  logic signed [DW-1:0] pbc [2];

  assign hx = -(40'(x) * C_HALF);
  assign sy = 40'(y) * C_HSQ3;

  // phases B and C differ only in the sign of the quadrature term
  for (genvar g = 0; g < 2; g++) begin : g_ph
    logic signed [39:0] acc;
    assign acc    = ((g == 0) ? (hx + sy + C_RND) : (hx - sy + C_RND)) >>> CF;
    assign pbc[g] = sat_dw(acc);
  end

  assign pa = x;
  assign pb = pbc[0];
  assign pc = pbc[1];
endmodule

// File: rtl/vrot_coproc.sv
module vrot_coproc
  import vrot_pkg::*;
#(
  parameter int ITER = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [1:0] rs_q;
  logic       rst_ni;
  logic       wr_q, wr_ev;
  logic       fwd_start, rev_start, fwd_busy, rev_busy;
  logic signed [DW-1:0] vd_q, vq_q, pa_q, pb_q, pc_q, al_q, be_q;
  logic signed [DW-1:0] al_c, be_c, fx, fy, oa, ob, oc, rd_d, rq;
  logic [DW-1:0] rev_ang, rd_val;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // write strobe rising edge while selected
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_n;
  end
  assign wr_ev     = !cs_n && wr_n && !wr_q;
  assign fwd_start = wr_ev && (addr == WA_FANG);
  assign rev_start = wr_ev && (addr == WA_RANG);
  assign rev_ang   = '0 - wdata;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vd_q <= '0;
      vq_q <= '0;
      pa_q <= '0;
      pb_q <= '0;
      pc_q <= '0;
      al_q <= '0;
      be_q <= '0;
    end else begin
      if (wr_ev && (addr == WA_VD)) vd_q <= wdata;
      if (wr_ev && (addr == WA_VQ)) vq_q <= wdata;
      if (wr_ev && (addr == WA_PA)) pa_q <= wdata;
      if (wr_ev && (addr == WA_PB)) pb_q <= wdata;
      if (wr_ev && (addr == WA_PC)) pc_q <= wdata;
      if (rev_start) begin
        al_q <= al_c;
        be_q <= be_c;
      end
    end
  end

  vrot_clarke u_clarke (
    .pa(pa_q), .pb(pb_q), .pc(pc_q), .alpha(al_c), .beta(be_c)
  );

  vrot_cordic #(.ITER(ITER)) u_fwd (
    .clk(clk), .rst_n(rst_ni), .start(fwd_start), .ang(wdata),
    .xin(vd_q), .yin(vq_q), .busy(fwd_busy), .xout(fx), .yout(fy)
  );

  vrot_cordic #(.ITER(ITER)) u_rev (
    .clk(clk), .rst_n(rst_ni), .start(rev_start), .ang(rev_ang),
    .xin(al_c), .yin(be_c), .busy(rev_busy), .xout(rd_d), .yout(rq)
  );

  vrot_iclarke u_iclarke (
    .x(fx), .y(fy), .pa(oa), .pb(ob), .pc(oc)
  );

  always_comb begin
    rd_val = '0;
    unique case (addr)
      RA_FX:   rd_val = fx;
      RA_FY:   rd_val = fy;
      RA_STAT: rd_val = {{(DW-2){1'b0}}, rev_busy, fwd_busy};
      RA_OA:   rd_val = oa;
      RA_OB:   rd_val = ob;
      RA_OC:   rd_val = oc;
      RA_AL:   rd_val = al_q;
      RA_BE:   rd_val = be_q;
      RA_D:    rd_val = rd_d;
      RA_Q:    rd_val = rq;
      default: rd_val = '0;
    endcase
  end
  assign rdata = (!cs_n && !rd_n) ? rd_val : '0;
endmodule

// File: rtl/vrot_coproc_chk.sv
module vrot_coproc_chk
  import vrot_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 rd_n,
  input logic                 wr_n,
  input logic [AW-1:0]        addr,
  input logic [DW-1:0]        rdata,
  input logic                 fwd_busy,
  input logic                 rev_busy,
  input logic signed [DW-1:0] fx
);
  logic wr_seen, f_go, r_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= 1'b1;
    else        wr_seen <= wr_n;
  end
  assign f_go = !cs_n && wr_n && !wr_seen && (addr == WA_FANG);
  assign r_go = !cs_n && wr_n && !wr_seen && (addr == WA_RANG);

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (rdata == '0)); // R3
  AST_FWD_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    f_go |=> fwd_busy); // R9
  AST_REV_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    r_go |=> rev_busy); // R9
  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && addr == RA_STAT) |-> (rdata[DW-1:2] == '0)); // R9
  AST_FX_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_busy && !f_go) |=> $stable(fx)); // R4
  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && addr > RA_Q) |-> (rdata == '0)); // R11
endmodule

bind vrot_coproc vrot_coproc_chk chk_i (
  .clk(clk), .rst_n(rst_ni), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .addr(addr), .rdata(rdata), .fwd_busy(fwd_busy), .rev_busy(rev_busy), .fx(fx)
);

// File: tb/vrot_coproc_tb_top.sv
`timescale 1ns/1ps
module vrot_coproc_tb_top;
  localparam int  ITER = 14;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst_n, cs_n, rd_n, wr_n;
  logic [3:0]  addr;
  logic [11:0] wdata, rdata;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vrot_coproc #(.ITER(ITER)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic int rsat(input real v);
    int r;
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input int tol);
    n_run++;
    if ((act - exp > tol) || (exp - act > tol)) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input int d, input bit sel = 1'b1);
    @(negedge clk);
    cs_n = !sel; addr = a; wdata = d[11:0]; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [3:0] a, output int v);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    v = int'($signed(rdata));
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic wait_busy(input int bitn, output int n);
    int s;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      bus_rd(4'd2, s);
      if (((s >> bitn) & 1) == 0) break;
      n++;
    end
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 10; a++) begin
      bus_rd(4'(a), v);
      chk($sformatf("R1 reset value at address %0d", a), v, 0, 0);
    end
  endtask

  task automatic t_forward(input int vd, input int vq, input int code);
    int n, x, y, pa, pb, pc;
    real th;
    th = TWO_PI * code / 4096.0;
    bus_wr(4'd0, vd);
    bus_wr(4'd1, vq);
    bus_wr(4'd2, code);
    wait_busy(0, n);
    chk("R9 forward busy cycles", n, ITER, 0);
    bus_rd(4'd0, x);
    bus_rd(4'd1, y);
    chk("R4 R8 forward X", x, rsat(vd * $cos(th) - vq * $sin(th)), 3);
    chk("R4 R8 forward Y", y, rsat(vd * $sin(th) + vq * $cos(th)), 3);
    bus_rd(4'd3, pa);
    bus_rd(4'd4, pb);
    bus_rd(4'd5, pc);
    chk("R5 phase A", pa, x, 0);
    chk("R5 R8 phase B", pb, rsat(-x / 2.0 + 0.8660254 * y), 1);
    chk("R5 R8 phase C", pc, rsat(-x / 2.0 - 0.8660254 * y), 1);
  endtask

  task automatic t_reverse(input int a, input int b, input int c, input int code);
    int n, al, be, d, q;
    real th;
    th = TWO_PI * code / 4096.0;
    bus_wr(4'd3, a);
    bus_wr(4'd4, b);
    bus_wr(4'd5, c);
    bus_wr(4'd6, code);
    wait_busy(1, n);
    chk("R9 reverse busy cycles", n, ITER, 0);
    bus_rd(4'd6, al);
    bus_rd(4'd7, be);
    chk("R6 alpha", al, rsat((2.0 * a - b - c) / 3.0), 1);
    chk("R6 beta", be, rsat((b - c) / $sqrt(3.0)), 1);
    bus_rd(4'd8, d);
    bus_rd(4'd9, q);
    chk("R7 flux d", d, rsat(al * $cos(th) + be * $sin(th)), 3);
    chk("R7 torque q", q, rsat(-al * $sin(th) + be * $cos(th)), 3);
  endtask

  task automatic t_restart();
    int n, x, y;
    real th;
    bus_wr(4'd0, 900);
    bus_wr(4'd1, 0);
    bus_wr(4'd2, 100);
    repeat (4) @(negedge clk);
    bus_wr(4'd0, -600);
    bus_wr(4'd2, 2000);
    wait_busy(0, n);
    chk("R10 busy counted from restart", n, ITER, 0);
    th = TWO_PI * 2000 / 4096.0;
    bus_rd(4'd0, x);
    bus_rd(4'd1, y);
    chk("R10 restarted X", x, rsat(-600.0 * $cos(th)), 3);
    chk("R10 restarted Y", y, rsat(-600.0 * $sin(th)), 3);
  endtask

  task automatic t_cs_ignore();
    int n, x;
    bus_wr(4'd0, 700);
    bus_wr(4'd1, 0);
    bus_wr(4'd0, -1234, 1'b0);
    bus_wr(4'd2, 0);
    wait_busy(0, n);
    bus_rd(4'd0, x);
    chk("R2 write without chip select ignored", x, 700, 3);
  endtask

  task automatic t_rd_gate();
    int x;
    bus_rd(4'd0, x);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0; addr = 4'd0;
    #1 chk("R3 bus idle without chip select", int'(rdata), 0, 0);
    cs_n = 1'b0; rd_n = 1'b1;
    #1 chk("R3 bus idle without read strobe", int'(rdata), 0, 0);
    cs_n = 1'b1;
    chk("R3 read of X is nonzero", (x != 0) ? 1 : 0, 1, 0);
  endtask

  task automatic t_reserved();
    int x0, x1, d0, d1, v;
    bus_rd(4'd0, x0);
    bus_wr(4'd12, 'h555);
    bus_rd(4'd12, v);
    chk("R11 reserved address reads zero", v, 0, 0);
    bus_wr(4'd15, 'h7AB);
    bus_rd(4'd0, x1);
    chk("R11 reserved write leaves X", x1, x0, 0);
    bus_rd(4'd8, d0);
    bus_wr(4'd8, 123);
    bus_rd(4'd8, d1);
    chk("R11 write to read-only address ignored", d1, d0, 0);
  endtask

  initial begin
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; wdata = '0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_forward(1000, 0, 512);
    t_forward(500, -300, 1024);
    t_forward(-700, 400, 3000);
    t_forward(0, 1500, 0);
    t_forward(2047, 2047, 512);
    t_forward(-2047, 2047, 0);
    t_rd_gate();
    t_cs_ignore();
    t_reverse(1000, -500, -500, 0);
    t_reverse(800, -900, 100, 700);
    t_reverse(-1200, 300, 900, 3500);
    t_restart();
    t_reserved();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=still running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule